// File: doc/BRIEF.md
# Banked Serial Memory Target (Two-Wire Bus)

This block is a two-wire serial bus target that serves a 1024-byte internal memory split into four banks of 256 bytes. A bus master opens a transaction with a Start, sends a control byte that carries a fixed device tag, two bank bits and a direction bit, and then either writes a word address (optionally followed by data bytes) or reads bytes back. The bank bits from a write-direction control byte become the upper part of the byte address, so one 8-bit word address reaches every location.

One address pointer is shared by all transactions and survives a Stop. Every completed data byte, read or written, moves it on by one, wrapping from the top of the array to zero. A read that is not preceded by a word address therefore continues from the last access plus one. A random read is a write-direction control byte and word address, then a repeated Start and a read-direction control byte. A sequential read continues for as long as the master acknowledges each byte.

The bus clock and data lines reach the block already synchronised and filtered. The data line is split into a sampled input and an output enable for an open-drain pad: when the enable is high, the pad pulls the line low.

Top module: `i2c_bank_mem_target`

## Requirements
- R1: After a synchronous active-low reset, and whenever the target is idle, `sda_oe` is low.
- R2: A control byte whose upper four bits are 1010 is acknowledged by holding `sda_oe` high for the ninth clock. Any other control byte gets no acknowledge, and every later bit is ignored until the next Start. The target asserts `sda_oe` during write-side traffic only in the acknowledge slot.
- R3: In a write-direction transaction, the byte after the control byte is acknowledged and loads the pointer with {control bits [2:1], word address}. Control bit 3 is don't-care and bit 0 is the direction, with 0 meaning write.
- R4: Each data byte that follows the word address is acknowledged, stored at the pointer, and then the pointer advances by one.
- R5: A repeated Start after the word address ends the write without storing anything. A following read-direction control byte (bit 0 = 1) returns the byte at the loaded address.
- R6: A read-direction control byte that is not preceded by a word address returns data from the current pointer. Its bank bits do not change the pointer.
- R7: Read data goes out MSB first, with `sda_oe` high for a 0 bit. `sda_oe` changes only while SCL is low.
- R8: After each transmitted byte the pointer advances by one. A master acknowledge (SDA low in the ninth clock) makes the target send the byte at the new pointer. A no-acknowledge releases the line and ends the read.
- R9: The pointer wraps from address 1023 to address 0, including in the middle of a sequential read.
- R10: A Start or Stop in any state clears the bit count. A Start begins a new control byte and a Stop returns the target to idle. A byte cut short by either of them is neither stored nor counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, already synchronised and filtered |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain pull-down enable for the data pad (1 = drive low) |

## Verification
A wrong pointer, bank latch or bit count inside this block always becomes visible on `sda_oe`. A misplaced count moves the acknowledge pull-down out of the ninth clock, or shifts read bits, within the same byte. A wrong pointer or a spurious store stays hidden until the next read, and then shows up as wrong data bits in the first byte returned. The bench therefore follows every write, aborted byte and rejected control byte with a current-address or random read that lands on the affected location. It also compares `sda_oe` against a behavioural model on every bit slot, so the failing byte and bit are reported directly.

// File: rtl/i2cm_pkg.sv
// Shared constants and types for the banked two-wire memory target.
// Assumes byte-wide bus transfers; only the bank count is configurable.
package i2cm_pkg;

    localparam int          WORD_W   = 8;        // bits per bus byte / word address
    localparam int          CNT_W    = 4;        // bit counter width (0..9)
    localparam logic [3:0]  CTRL_TAG = 4'b1010;  // required upper nibble of the control byte

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_CTRL  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_WDATA = 3'd3,
        ST_READ  = 3'd4
    } tgt_state_e;

endpackage

// File: rtl/i2cm_line_watch.sv
// Bus line watcher: registers the synchronised SCL/SDA inputs once more and
// derives clock edges and Start/Stop conditions as one-cycle pulses.
// Assumes both inputs are already free of metastability and glitches.
module i2cm_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev,
    output logic sda_bit
);

    logic scl_now, sda_now, scl_prev, sda_prev;

    // Two-deep history of both lines; reset to the released (high) level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_now  <= 1'b1;
            sda_now  <= 1'b1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_now  <= scl_in;
            sda_now  <= sda_in;
            scl_prev <= scl_now;
            sda_prev <= sda_now;
        end
    end

    assign scl_rise = scl_now & ~scl_prev;
    assign scl_fall = ~scl_now & scl_prev;
    assign start_ev = scl_now & scl_prev & sda_prev & ~sda_now;
    assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_now;
    assign sda_bit  = sda_now;

endmodule

// File: rtl/i2cm_ptr.sv
// Shared address pointer: a load from the word-address phase wins over the
// increment issued after each completed data byte. Wraps at 2**ADDR_W.
module i2cm_ptr #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] ptr
);

    // Hold, load or advance the pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + ADDR_W'(1);
        end
    end

endmodule

// File: rtl/i2cm_store.sv
// Byte storage: one synchronous write port and one asynchronous read port,
// both addressed by the shared pointer. Contents are not reset.
module i2cm_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Write a byte when the protocol engine commits one.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/i2cm_proto.sv
// Protocol engine: counts SCL rising edges within each 9-bit slot, shifts in
// control/address/data bytes, drives acknowledges and read data on SCL falling
// edges, and issues pointer load/advance and store strobes.
// Assumes the edge and condition pulses from i2cm_line_watch.
module i2cm_proto
    import i2cm_pkg::*;
#(
    parameter int BANK_BITS = 2,
    parameter int ADDR_W    = BANK_BITS + WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              sda_bit,
    input  logic [WORD_W-1:0] rdata,
    output logic              sda_oe,
    output logic              ptr_load,
    output logic [ADDR_W-1:0] ptr_load_val,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_data,
    output logic              rd_done,
    output tgt_state_e        state,
    output logic [CNT_W-1:0]  bitcnt
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] ACK_BIT  = CNT_W'(WORD_W + 1);

    tgt_state_e             state_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [WORD_W-1:0]      sh_q;
    logic                   oe_q;
    logic [BANK_BITS-1:0]   bank_q;
    logic                   rw_q;
    logic                   mack_q;
    logic                   byte_end;

    assign byte_end = scl_fall && (cnt_q == LAST_BIT);

    // One-cycle strobes at the falling edge that closes a byte's eighth bit.
    always_comb begin
        ptr_load = 1'b0;
        wr_en    = 1'b0;
        rd_done  = 1'b0;
        if (byte_end) begin
            case (state_q)
                ST_ADDR:  ptr_load = 1'b1;
                ST_WDATA: wr_en    = 1'b1;
                ST_READ:  rd_done  = 1'b1;
                default:  ;
            endcase
        end
    end

    assign ptr_load_val = {bank_q, sh_q};
    assign wr_data      = sh_q;

    // Main sequencer: conditions first, then rising-edge sampling, then
    // falling-edge driving of the data line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            oe_q    <= 1'b0;
            bank_q  <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
        end else if (start_ev) begin
            state_q <= ST_CTRL;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else if (stop_ev) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
        end else if (scl_rise && state_q != ST_IDLE) begin
            if (cnt_q < LAST_BIT) begin
                if (state_q != ST_READ) begin
                    sh_q <= {sh_q[WORD_W-2:0], sda_bit};
                end
            end else if (state_q == ST_READ) begin
                mack_q <= ~sda_bit;
            end
            if (cnt_q != ACK_BIT) begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end else if (scl_fall) begin
            case (state_q)
                ST_CTRL: begin
                    if (cnt_q == LAST_BIT) begin
                        if (sh_q[WORD_W-1:WORD_W-4] == CTRL_TAG) begin
                            oe_q   <= 1'b1;
                            bank_q <= sh_q[BANK_BITS:1];
                            rw_q   <= sh_q[0];
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end else if (cnt_q == ACK_BIT) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            state_q <= ST_READ;
                            sh_q    <= rdata;
                            oe_q    <= ~rdata[WORD_W-1];
                        end else begin
                            state_q <= ST_ADDR;
                            oe_q    <= 1'b0;
                        end
                    end
                end
                ST_ADDR, ST_WDATA: begin
                    if (cnt_q == LAST_BIT) begin
                        oe_q <= 1'b1;
                    end else if (cnt_q == ACK_BIT) begin
                        oe_q    <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_WDATA;
                    end
                end
                ST_READ: begin
                    if (cnt_q != '0 && cnt_q < LAST_BIT) begin
                        sh_q <= {sh_q[WORD_W-2:0], 1'b0};
                        oe_q <= ~sh_q[WORD_W-2];
                    end else if (cnt_q == LAST_BIT) begin
                        oe_q <= 1'b0;
                    end else if (cnt_q == ACK_BIT) begin
                        cnt_q <= '0;
                        if (mack_q) begin
                            sh_q <= rdata;
                            oe_q <= ~rdata[WORD_W-1];
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe = oe_q;
    assign state  = state_q;
    assign bitcnt = cnt_q;

endmodule

// File: rtl/i2c_bank_mem_target.sv
// Top level of the banked two-wire memory target. Connects the line watcher,
// protocol engine, shared pointer and byte storage. Assumes SCL/SDA arrive
// synchronised and filtered; sda_oe drives an open-drain pull-down.
module i2c_bank_mem_target
    import i2cm_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe
);

    localparam int ADDR_W = BANK_BITS + WORD_W;

    logic              scl_rise, scl_fall, start_ev, stop_ev, sda_bit;
    logic              ptr_load, wr_en, rd_done, ptr_inc;
    logic [ADDR_W-1:0] ptr_load_val, ptr;
    logic [WORD_W-1:0] wr_data, rdata;
    tgt_state_e        state_w;
    logic [CNT_W-1:0]  bitcnt_w;

    i2cm_line_watch u_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .sda_bit  (sda_bit)
    );

    i2cm_proto #(
        .BANK_BITS (BANK_BITS),
        .ADDR_W    (ADDR_W)
    ) u_proto (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_ev     (start_ev),
        .stop_ev      (stop_ev),
        .sda_bit      (sda_bit),
        .rdata        (rdata),
        .sda_oe       (sda_oe),
        .ptr_load     (ptr_load),
        .ptr_load_val (ptr_load_val),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_done      (rd_done),
        .state        (state_w),
        .bitcnt       (bitcnt_w)
    );

    assign ptr_inc = wr_en | rd_done;

    i2cm_ptr #(
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ptr_load_val),
        .inc      (ptr_inc),
        .ptr      (ptr)
    );

    i2cm_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (WORD_W)
    ) u_store (
        .clk   (clk),
        .we    (wr_en),
        .addr  (ptr),
        .wdata (wr_data),
        .rdata (rdata)
    );

endmodule

// File: rtl/i2cm_checker.sv
// Protocol checker bound to the target top: watches ports and the signals
// passed between its sub-blocks.
module i2cm_checker
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_in,
    input logic              sda_oe,
    input tgt_state_e        state,
    input logic [CNT_W-1:0]  bitcnt,
    input logic [ADDR_W-1:0] ptr,
    input logic              wr_en,
    input logic              rd_done,
    input logic              start_ev,
    input logic              stop_ev
);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);

    assert_ack_slot_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe && (state == ST_CTRL || state == ST_ADDR || state == ST_WDATA))
        |-> (bitcnt >= CNT_W'(WORD_W)));

    assert_write_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ptr == $past(ptr) + ADDR_W'(1)));

    assert_scl_high_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in)) |-> $stable(sda_oe));

    // The pointer increment checked here also covers the top-to-zero wrap (R9).
    assert_read_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (ptr == $past(ptr) + ADDR_W'(1)));

    assert_start_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_CTRL && bitcnt == '0));

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE && !sda_oe));

endmodule

bind i2c_bank_mem_target i2cm_checker #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_oe   (sda_oe),
    .state    (state_w),
    .bitcnt   (bitcnt_w),
    .ptr      (ptr),
    .wr_en    (wr_en),
    .rd_done  (rd_done),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
);

// File: tb/i2c_bank_mem_target_bench.sv
// Bench: a bus master model drives SCL/SDA; a behavioural memory and pointer
// predict sda_oe for every bit slot, compared away from the clock edge.
module i2c_bank_mem_target_bench;

    localparam int Q = 4;   // clock cycles per SCL half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic sda_bus;

    int n_cmp = 0;
    int n_bad = 0;

    logic [7:0] mem_m [0:1023];
    int         ptr_m = 0;

    always #5 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_bank_mem_target u_i2c_bank_mem_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_m),
        .sda_in (sda_bus),
        .sda_oe (sda_oe)
    );

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input logic got, input logic exp, input string req);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: sda_oe got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    // One bit slot: master level on SDA, expected target pull-down mid-high.
    task automatic bit_slot(input logic b, input logic exp_oe, input string req);
        sda_m = b;
        hold(Q);
        scl_m = 1'b1;
        hold(Q / 2);
        check(sda_oe, exp_oe, req);
        hold(Q / 2);
        scl_m = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        hold(Q);
        scl_m = 1'b1;
        hold(Q);
        sda_m = 1'b0;
        hold(Q);
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        hold(Q);
        scl_m = 1'b1;
        hold(Q);
        sda_m = 1'b1;
        hold(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
        for (int i = 7; i >= 0; i--) bit_slot(b[i], 1'b0, req);
        bit_slot(1'b1, exp_ack, req);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string req);
        for (int i = 7; i >= 0; i--) bit_slot(1'b1, ~exp[i], {req, " R7"});
        bit_slot(~mack, 1'b0, req);
    endtask

    function automatic logic [7:0] ctrl(input logic [1:0] bank, input logic rd);
        return {4'b1010, 1'b0, bank, rd};
    endfunction

    task automatic recv_run(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            recv_byte(mem_m[ptr_m], (k < n - 1), req);
            ptr_m = (ptr_m + 1) % 1024;
        end
    endtask

    task automatic wr(input logic [1:0] bank, input logic [7:0] word, input int n,
                      input logic [7:0] b0, input logic [7:0] b1, input logic [7:0] b2);
        logic [7:0] d [3];
        d[0] = b0; d[1] = b1; d[2] = b2;
        bus_start();
        send_byte(ctrl(bank, 1'b0), 1'b1, "R2");
        send_byte(word, 1'b1, "R3");
        ptr_m = {22'd0, bank, word};
        for (int k = 0; k < n; k++) begin
            send_byte(d[k], 1'b1, "R4");
            mem_m[ptr_m] = d[k];
            ptr_m = (ptr_m + 1) % 1024;
        end
        bus_stop();
    endtask

    task automatic rd_rand(input logic [1:0] bank, input logic [7:0] word, input int n,
                           input string req);
        bus_start();
        send_byte(ctrl(bank, 1'b0), 1'b1, "R2");
        send_byte(word, 1'b1, "R3");
        ptr_m = {22'd0, bank, word};
        bus_start();
        send_byte(ctrl(bank, 1'b1), 1'b1, "R5");
        recv_run(n, req);
        bus_stop();
    endtask

    task automatic rd_cur(input logic [1:0] bank, input int n, input string req);
        bus_start();
        send_byte(ctrl(bank, 1'b1), 1'b1, req);
        recv_run(n, req);
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        hold(5);
        check(sda_oe, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        hold(4 * Q);
        check(sda_oe, 1'b0, "R1 after reset");

        // R4: multi-byte write; R3: banked addresses; wrap material for R9.
        wr(2'd0, 8'h10, 3, 8'hA5, 8'h3C, 8'hF0);
        wr(2'd2, 8'h80, 1, 8'h81, 8'h00, 8'h00);
        wr(2'd3, 8'hFE, 2, 8'h11, 8'h22, 8'h00);
        wr(2'd0, 8'h00, 1, 8'h99, 8'h00, 8'h00);

        // R5 random read, R8 sequential continuation.
        rd_rand(2'd0, 8'h10, 3, "R5/R8");
        // R3 bank bits select a distinct bank.
        rd_rand(2'd2, 8'h80, 1, "R3");
        // R6 current-address read; bank bits of read control byte ignored.
        rd_rand(2'd0, 8'h10, 1, "R5");
        rd_cur(2'd3, 1, "R6");
        rd_cur(2'd1, 1, "R6");
        // R9 wrap from 1023 to 0 inside a sequential read.
        rd_rand(2'd3, 8'hFE, 3, "R9");

        // R2 rejected control byte: no acknowledge, rest ignored, pointer kept.
        rd_rand(2'd0, 8'h10, 1, "R2");
        bus_start();
        send_byte(8'hB2, 1'b0, "R2 bad tag");
        send_byte(8'h00, 1'b0, "R2 ignored");
        send_byte(8'h55, 1'b0, "R2 ignored");
        bus_stop();
        rd_cur(2'd0, 1, "R2 pointer kept");

        // R10 Stop in mid data byte: nothing stored, pointer not advanced.
        bus_start();
        send_byte(ctrl(2'd0, 1'b0), 1'b1, "R10");
        send_byte(8'h11, 1'b1, "R10");
        ptr_m = 'h011;
        for (int i = 0; i < 4; i++) bit_slot(1'b0, 1'b0, "R10");
        bus_stop();
        rd_cur(2'd0, 1, "R10 no store");

        // R10 repeated Start in mid byte restarts the control byte count.
        bus_start();
        send_byte(ctrl(2'd0, 1'b0), 1'b1, "R10");
        for (int i = 0; i < 3; i++) bit_slot(1'b1, 1'b0, "R10");
        bus_start();
        send_byte(ctrl(2'd0, 1'b1), 1'b1, "R10 restart");
        recv_run(1, "R10");
        bus_stop();

        // R1 idle after all traffic.
        hold(4 * Q);
        check(sda_oe, 1'b0, "R1 idle");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule